// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block runs the arithmetic and logic instructions of a 16-bit load/store processor: two's-complement add, bitwise AND and bitwise complement. It holds eight general registers. The block decodes each instruction word presented with the execute strobe. It reads one or two source registers, and for add and AND it may use a short sign-extended immediate in place of the second register. The result goes back to the destination register. Every write also refreshes a three-flag condition state that reports whether the written value is negative, zero or positive.

The write port is shown at the outputs during the strobe cycle, before the edge that commits it. A surrounding core can therefore watch or forward the result. Instructions enter on a plain strobe that is accepted on every cycle. There is no back-pressure: one instruction retires per strobed clock edge, and a source register written by the previous strobe already holds the new value. Memory access, fetch and program-counter control sit outside the block.

Top module: `opu_top`

## Requirements
- R1: After reset, all eight registers read as 0 and the flags are N=0, Z=1, P=0.
- R2: Opcode 0001 in bits [15:12] adds. With bit 5 at 0 and bits [4:3] at 0, the sum of the register in bits [8:6] and the register in bits [2:0] is written, modulo 2^16, to the register in bits [11:9].
- R3: With bit 5 at 1, add and AND take their second operand from bits [4:0] sign-extended to 16 bits.
- R4: Opcode 0101 writes the bitwise AND of its two operands, with the same field layout as add.
- R5: Opcode 1001 with bits [5:0] all ones writes the bitwise complement of the register in bits [8:6] to the register in bits [11:9].
- R6: On every register write, exactly one of N, Z, P becomes 1 from the next cycle on. N is 1 when bit 15 of the written value is 1, Z when the value is 0, and P otherwise.
- R7: A strobed word whose opcode is not 0001, 0101 or 1001 leaves wr_en low, changes no register and leaves the flags unchanged.
- R8: A malformed operate word is rejected like an unknown opcode. This covers add or AND in register mode with bits [4:3] not 00, and complement with bits [5:0] not 111111.
- R9: With exec_en low, no write and no flag change happen, whatever instr holds.
- R10: wr_en, wr_idx and wr_data show the pending write in the strobe cycle. The register takes the value at that clock edge, and a later instruction reads it, including one that names the same register as source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; the instruction retires at this edge |
| instr | input | 16 | Instruction word |
| wr_en | output | 1 | A register write commits at the coming edge |
| wr_idx | output | 3 | Destination register number |
| wr_data | output | 16 | Value being written |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
A corrupted register entry stays hidden until an instruction reads it. After that it shows in wr_data in the same strobe cycle, so the bench reads every register it relies on back through an add of immediate zero. A wrong flag register is visible on the flag pins one cycle after the write that set it. A decode fault that wrongly accepts or rejects a word shows at once on wr_en, and one cycle later as a flag change or a missing flag change.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int unsigned INSN_W = 16;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned IMM_W  = 5;

  typedef enum logic [3:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opc_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_INV = 2'd2
  } fn_e;

  typedef struct packed {
    logic             wr;
    fn_e              fn;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srca;
    logic [IDX_W-1:0] srcb;
    logic             use_imm;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);
  logic [3:0] opc;
  logic       low_ones;
  logic       pad_zero;

  assign opc      = instr[15:12];
  assign low_ones = &instr[5:0];
  assign pad_zero = (instr[4:3] == 2'b00);

  always_comb begin
    dec         = '0;
    dec.dst     = instr[11:9];
    dec.srca    = instr[8:6];
    dec.srcb    = instr[2:0];
    dec.use_imm = instr[5];
    dec.imm     = instr[4:0];
    dec.fn      = FN_ADD;
    unique case (opc)
      OPC_ADD: begin
        dec.fn = FN_ADD;
        dec.wr = exec_en && (instr[5] || pad_zero);
      end
      OPC_AND: begin
        dec.fn = FN_AND;
        dec.wr = exec_en && (instr[5] || pad_zero);
      end
      OPC_NOT: begin
        dec.fn = FN_INV;
        dec.wr = exec_en && low_ones;
      end
      default: dec.wr = 1'b0;
    endcase
  end

  assert_wr_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr |-> exec_en);
  assert_unknown_opc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != 4'b0001 && opc != 4'b0101 && opc != 4'b1001) |-> !dec.wr);
endmodule

// File: rtl/opu_regfile.sv
module opu_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned RPORTS = 2,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [RPORTS*AW-1:0]   raddr,
  output logic [RPORTS*DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rd
    assign rdata[p*DATA_W +: DATA_W] = mem[raddr[p*AW +: AW]];
  end

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fn_e               fn,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb_reg,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;

  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign opb     = use_imm ? imm_ext : opb_reg;

  always_comb begin
    unique case (fn)
      FN_ADD:  result = opa + opb;
      FN_AND:  result = opa & opb;
      FN_INV:  result = ~opa;
      default: result = '0;
    endcase
  end

  assert_and_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_AND) |-> ((result & ~opa) == '0));
  assert_inv_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_INV) |-> ((result & opa) == '0));
endmodule

// File: rtl/opu_flags.sv
module opu_flags #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] val,
  output logic              neg,
  output logic              zero,
  output logic              pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg  <= 1'b0;
      zero <= 1'b1;
      pos  <= 1'b0;
    end else if (upd) begin
      neg  <= val[DATA_W-1];
      zero <= (val == '0);
      pos  <= !val[DATA_W-1] && (val != '0);
    end
  end

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({neg, zero, pos}) == 1);
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({neg, zero, pos}));
  assert_zero_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> zero == ($past(val) == '0));
endmodule

// File: rtl/opu_top.sv
module opu_top
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [15:0]       instr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  dec_t                dec;
  logic [2*AW-1:0]     rd_addr;
  logic [2*DATA_W-1:0] rd_data;
  logic [DATA_W-1:0]   result;

  opu_decode u_dec (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr), .dec(dec)
  );

  assign rd_addr = {dec.srcb[AW-1:0], dec.srca[AW-1:0]};

  opu_regfile #(.DATA_W(DATA_W), .DEPTH(NREGS), .RPORTS(2)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(dec.wr), .waddr(dec.dst[AW-1:0]),
    .wdata(result), .raddr(rd_addr), .rdata(rd_data)
  );

  opu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .fn(dec.fn), .use_imm(dec.use_imm), .imm(dec.imm),
    .opa(rd_data[DATA_W-1:0]), .opb_reg(rd_data[2*DATA_W-1:DATA_W]),
    .result(result)
  );

  opu_flags #(.DATA_W(DATA_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .upd(dec.wr), .val(result),
    .neg(flag_n), .zero(flag_z), .pos(flag_p)
  );

  assign wr_en   = dec.wr;
  assign wr_idx  = dec.dst[AW-1:0];
  assign wr_data = result;

  assert_neg_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flag_n == $past(wr_data[DATA_W-1]));
endmodule

// File: tb/sim_opu_top.sv
module sim_opu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [15:0] instr = '0;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic        flag_n, flag_z, flag_p;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mregs [8];
  logic [2:0]  mflag;  // {n,z,p}

  always #4 clk = ~clk;

  opu_top u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] op, input int d, input int a, input int b);
    return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] enc_i(input logic [3:0] op, input int d, input int a, input int im);
    return {op, 3'(d), 3'(a), 1'b1, 5'(im)};
  endfunction
  function automatic logic [15:0] enc_n(input int d, input int a);
    return {4'b1001, 3'(d), 3'(a), 6'b111111};
  endfunction

  // Model from the requirements
  function automatic logic model(input logic [15:0] w, output logic [15:0] v);
    logic [15:0] a, b;
    a = mregs[w[8:6]];
    b = w[5] ? {{11{w[4]}}, w[4:0]} : mregs[w[2:0]];
    v = '0;
    case (w[15:12])
      4'b0001: begin v = a + b; return w[5] || (w[4:3] == 2'b00); end
      4'b0101: begin v = a & b; return w[5] || (w[4:3] == 2'b00); end
      4'b1001: begin v = ~a;    return w[5:0] == 6'h3f; end
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input logic [15:0] w, input logic en, input string req);
    logic ok;
    logic [15:0] v;
    logic [2:0] nf;
    ok = en && model(w, v);
    @(negedge clk);
    instr = w;
    exec_en = en;
    #1;
    chk(wr_en == ok, req, 32'(wr_en), 32'(ok));
    if (ok) begin
      chk(wr_idx == w[11:9], req, 32'(wr_idx), 32'(w[11:9]));
      chk(wr_data == v, req, 32'(wr_data), 32'(v));
    end
    @(posedge clk);
    #1;
    exec_en = 1'b0;
    if (ok) begin
      mregs[w[11:9]] = v;
      nf = v[15] ? 3'b100 : (v == 0 ? 3'b010 : 3'b001);
      mflag = nf;
    end
    chk({flag_n, flag_z, flag_p} == mflag, {req, " R6 flags"},
        32'({flag_n, flag_z, flag_p}), 32'(mflag));
  endtask

  task automatic peek(input int r, input string req);
    run(enc_i(4'b0001, r, r, 0), 1'b1, req);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 8; r++) mregs[r] = '0;
    mflag = 3'b010;
    #1;
    chk({flag_n, flag_z, flag_p} == 3'b010, "R1 reset flags", 32'({flag_n, flag_z, flag_p}), 32'h2);
    for (int r = 0; r < 8; r++) begin
      logic [15:0] v;
      @(negedge clk);
      instr = enc_i(4'b0001, 0, r, 0);
      exec_en = 1'b1;
      #1;
      v = wr_data;
      chk(v == 16'h0, "R1 reset register", 32'(v), 32'h0);
      exec_en = 1'b0;
      @(posedge clk);
      #1;
      mregs[0] = 16'h0;
    end
  endtask

  task automatic t_imm;
    run(enc_i(4'b0001, 1, 0, 5), 1'b1, "R3 add imm +5");
    run(enc_i(4'b0001, 2, 0, -16), 1'b1, "R3 add imm -16");
    run(enc_i(4'b0101, 3, 2, 5'h1c), 1'b1, "R3 R4 and imm");
  endtask

  task automatic t_reg;
    run(enc_r(4'b0001, 4, 1, 2), 1'b1, "R2 add reg");
    run(enc_r(4'b0101, 5, 4, 1), 1'b1, "R4 and reg");
    run(enc_r(4'b0001, 1, 1, 1), 1'b1, "R10 same src dst");
    peek(1, "R10 readback");
  endtask

  task automatic t_not_wrap;
    run(enc_n(6, 0), 1'b1, "R5 not zero");
    run(enc_i(4'b0001, 7, 6, 1), 1'b1, "R2 wrap to zero");
    run(enc_n(6, 2), 1'b1, "R5 not neg");
    run(enc_i(4'b0001, 0, 6, 0), 1'b1, "R6 positive");
  endtask

  task automatic t_reject;
    run(16'h0e05, 1'b1, "R7 branch opcode");
    run(16'h2a10, 1'b1, "R7 load opcode");
    run(16'hf025, 1'b1, "R7 trap opcode");
    run({4'b0001, 3'd1, 3'd1, 3'b010, 3'd2}, 1'b1, "R8 add pad bits");
    run({4'b0101, 3'd1, 3'd1, 3'b001, 3'd2}, 1'b1, "R8 and pad bits");
    run({4'b1001, 3'd1, 3'd2, 6'b111110}, 1'b1, "R8 not low bits");
    run(enc_n(1, 1), 1'b0, "R9 no strobe");
    peek(1, "R7 R8 R9 reg unchanged");
    peek(6, "R10 reg readback");
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_imm();
    t_reg();
    t_not_wrap();
    t_reject();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule